// File: doc/BRIEF.md
# Multi-Mode Serial Port

A full-duplex serial port whose behaviour is picked by a two-bit mode field in its control register. Mode 0 is a synchronous shifter. Eight bits move on the data pin, least significant first, and the transmit line carries the shift clock. Mode 1 is an asynchronous link with a 10-bit frame. Modes 2 and 3 are asynchronous links with an 11-bit frame, whose ninth data bit is programmable.

The bit rate of mode 0 and of mode 2 is a fixed division of the core clock. Modes 1 and 3 take their rate from an overflow tick supplied by an external timer. A doubling input halves the bit period in modes 1, 2 and 3.

The asynchronous receiver oversamples every bit. It decides each bit by a majority of three samples taken around mid-bit, and it rejects a start bit that has gone back high by mid-bit. In modes 2 and 3 a filter bit keeps the receive flag low except on frames whose ninth bit is 1. This lets many nodes share one line and wake only on address frames. In mode 1 the same filter bit drops frames that have a bad stop bit. The transmit and receive flags are set by the hardware and cleared by software.

Top module: `ser_port`

## Requirements
- R1: The control register reads back on `ctl_o` with this layout: bits [1:0] mode, bit 2 receive enable, bit 3 filter, bit 4 transmit ninth bit, bit 5 received ninth bit, bit 6 transmit flag, bit 7 receive flag. A control write loads all eight bits. After reset the register is 0 and `txd_o` is high.
- R2: In mode 0, a write to the transmit data register shifts the byte out on `dat_o`, least significant bit first, with `dat_oe_o` high. `txd_o` carries a shift clock whose period is SHIFT_DIV clocks: low for the first half of each bit and rising at mid-bit, where the data bit is stable. The transmit flag (bit 6) is set afterwards.
- R3: In mode 0, a control write that leaves mode 0 with receive enable 1 and receive flag 0 starts eight shift clocks. `rxd_i` is sampled at each rising edge, least significant bit first. The byte appears on `rx_data_o` and the receive flag is set.
- R4: Mode 1 sends a 10-bit frame on `txd_o`: a start bit 0, eight data bits least significant first, and a stop bit 1. The bit period is OVS*TMR_PRE timer ticks, or OVS ticks when `dbl_i` is 1.
- R5: Modes 2 and 3 send an 11-bit frame. The ninth bit is taken from control bit 4 and placed between the data and the stop bit. Mode 2 bit period: FIX_DIV clocks, or FIX_DIV/2 with `dbl_i`. Mode 3 bit period: as in R4.
- R6: The receiver takes each bit as the majority of three oversamples around mid-bit. A low pulse on an idle line that has ended by mid-bit is not taken as a start bit. On an accepted frame, bit 5 receives the ninth bit in modes 2 and 3, and the stop bit in mode 1.
- R7: With the filter bit set, a mode 2 or 3 frame whose ninth bit is 0 is dropped (no flag, buffer unchanged), and a mode 1 frame with stop bit 0 is dropped. With the filter bit clear, both kinds are accepted, and in mode 1 bit 5 then reads 0.
- R8: Both flags are set only by the hardware at the end of a frame and are cleared only by a control write. A hardware set wins over a write in the same cycle.
- R9: While the receive flag is 1, a completed frame does not change `rx_data_o` or the flag. After software clears the flag, the next frame is received.
- R10: With receive enable 0, nothing is received in any mode. A mode 0 control write with receive enable 0 starts no shift clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_tick_i | input | 1 | One-cycle overflow pulse from an external timer |
| dbl_i | input | 1 | Bit-rate doubling select |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write value |
| tx_wr_i | input | 1 | Transmit data write strobe; starts a frame |
| tx_wdata_i | input | 8 | Byte to transmit |
| rxd_i | input | 1 | Serial input (mode 0 data input) |
| ctl_o | output | 8 | Control register contents |
| rx_data_o | output | 8 | Last accepted received byte |
| txd_o | output | 1 | Serial output; shift clock in mode 0 |
| dat_o | output | 1 | Mode 0 transmit data |
| dat_oe_o | output | 1 | Drive enable for `dat_o` |
| tx_irq_o | output | 1 | Transmit flag |
| rx_irq_o | output | 1 | Receive flag |

## Verification
The bench builds the port with its default parameters: SHIFT_DIV 12, FIX_DIV 64, OVS 16 and TMR_PRE 2. It drives a timer tick every third clock. Bit periods are therefore 12, 32, 48, 64 or 96 clocks, short enough that every mode, each doubling setting and both filter settings can be run on whole frames in both directions. The short mode 0 clock makes it quick to measure the shift-clock period exactly. The 16-fold oversampling leaves wide margins, so a glitch on the start bit can be placed cleanly before the mid-bit vote.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    MD_SHIFT  = 2'b00,
    MD_UART8  = 2'b01,
    MD_UART9F = 2'b10,
    MD_UART9T = 2'b11
  } sp_mode_e;

  typedef struct packed {
    logic       rx_flag;
    logic       tx_flag;
    logic       rx_b9;
    logic       tx_b9;
    logic       filt;
    logic       en_rx;
    logic [1:0] mode;
  } sp_ctl_t;
endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
  parameter int FIX_DIV = 64,
  parameter int TMR_PRE = 2,
  parameter int OVS     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       dbl,
  input  logic       tmr_tick,
  output logic       os_tick
);
  import sp_pkg::*;
  localparam int FIX_OS = FIX_DIV / OVS;
  localparam int FW     = $clog2(FIX_OS + 1);
  localparam int PW     = $clog2(TMR_PRE + 1);

  logic [FW-1:0] fcnt, flim;
  logic [PW-1:0] pcnt;
  logic          fix_hit, tmr_hit;

  assign flim    = dbl ? FW'(FIX_OS / 2) : FW'(FIX_OS);
  assign fix_hit = (fcnt >= flim - 1'b1);
  assign tmr_hit = tmr_tick && (dbl || pcnt == PW'(TMR_PRE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt    <= '0;
      pcnt    <= '0;
      os_tick <= 1'b0;
    end else begin
      fcnt <= fix_hit ? '0 : fcnt + 1'b1;
      if (tmr_tick)
        pcnt <= (pcnt == PW'(TMR_PRE - 1)) ? '0 : pcnt + 1'b1;
      case (sp_mode_e'(mode))
        MD_UART9F:            os_tick <= fix_hit;
        MD_UART8, MD_UART9T:  os_tick <= tmr_hit;
        default:              os_tick <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       nine,
  input  logic       os_tick,
  input  logic [7:0] din,
  input  logic       b9,
  output logic       txd,
  output logic       done
);
  localparam int CW = $clog2(OVS);

  logic [10:0]   sh;
  logic [3:0]    idx, lastq;
  logic [CW-1:0] ocnt;
  logic          busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '1;
      idx   <= '0;
      lastq <= 4'd9;
      ocnt  <= '0;
      busy  <= 1'b0;
      txd   <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sh    <= {1'b1, (nine ? b9 : 1'b1), din, 1'b0};
          lastq <= nine ? 4'd10 : 4'd9;
          idx   <= '0;
          ocnt  <= '0;
          busy  <= 1'b1;
          txd   <= 1'b0;
        end
      end else if (os_tick) begin
        if (ocnt == CW'(OVS - 1)) begin
          ocnt <= '0;
          if (idx == lastq) begin
            busy <= 1'b0;
            done <= 1'b1;
            txd  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            sh  <= {1'b1, sh[10:1]};
            txd <= sh[1];
          end
        end else begin
          ocnt <= ocnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       nine,
  input  logic       os_tick,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] dout,
  output logic       bit9,
  output logic       stopb
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  logic          s1, s2, active, sa, sb, vote;
  logic [3:0]    idx, last;
  logic [CW-1:0] ocnt;

  assign vote = (sa & sb) | (sa & s2) | (sb & s2);
  assign last = nine ? 4'd10 : 4'd9;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1;
      active <= 1'b0;
      sa <= 1'b1; sb <= 1'b1;
      idx <= '0; ocnt <= '0;
      done <= 1'b0; dout <= '0; bit9 <= 1'b0; stopb <= 1'b1;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      done <= 1'b0;
      if (!en) begin
        active <= 1'b0;
      end else if (os_tick) begin
        if (!active) begin
          if (!s2) begin
            active <= 1'b1;
            idx    <= '0;
            ocnt   <= '0;
          end
        end else begin
          ocnt <= (ocnt == CW'(OVS - 1)) ? '0 : ocnt + 1'b1;
          if (ocnt == CW'(OVS - 1)) idx <= idx + 1'b1;
          if (ocnt == CW'(MID - 1)) sa <= s2;
          if (ocnt == CW'(MID))     sb <= s2;
          if (ocnt == CW'(MID + 1)) begin
            if (idx == 4'd0) begin
              if (vote) active <= 1'b0;
            end else if (idx <= 4'd8) begin
              dout <= {vote, dout[7:1]};
            end else if (idx == 4'd9 && nine) begin
              bit9 <= vote;
            end
            if (idx == last) begin
              active <= 1'b0;
              done   <= 1'b1;
              stopb  <= vote;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sp_shift0.sv
module sp_shift0 #(
  parameter int DIV = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_go,
  input  logic       rx_go,
  input  logic [7:0] din,
  input  logic       rxd,
  output logic       sclk,
  output logic       dout,
  output logic       doe,
  output logic       tx_done,
  output logic       rx_done,
  output logic [7:0] rx_data
);
  localparam int PW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic          busy, dir_rx;
  logic [PW-1:0] ph;
  logic [2:0]    bcnt;
  logic [7:0]    sh;

  assign dout    = sh[0];
  assign doe     = busy & ~dir_rx;
  assign rx_data = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; dir_rx <= 1'b0;
      ph <= '0; bcnt <= '0; sh <= '0;
      sclk <= 1'b1; tx_done <= 1'b0; rx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      if (!busy) begin
        if (tx_go || rx_go) begin
          busy   <= 1'b1;
          dir_rx <= ~tx_go;
          ph     <= '0;
          bcnt   <= '0;
          sclk   <= 1'b0;
          if (tx_go) sh <= din;
        end
      end else begin
        ph <= (ph == PW'(DIV - 1)) ? '0 : ph + 1'b1;
        if (ph == PW'(HALF - 1)) begin
          sclk <= 1'b1;
          if (dir_rx) sh <= {rxd, sh[7:1]};
        end
        if (ph == PW'(DIV - 1)) begin
          if (bcnt == 3'd7) begin
            busy <= 1'b0;
            if (dir_rx) rx_done <= 1'b1;
            else        tx_done <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
            sclk <= 1'b0;
            if (!dir_rx) sh <= {1'b0, sh[7:1]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/ser_port.sv
module ser_port #(
  parameter int SHIFT_DIV = 12,
  parameter int FIX_DIV   = 64,
  parameter int TMR_PRE   = 2,
  parameter int OVS       = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tmr_tick_i,
  input  logic       dbl_i,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_wdata_i,
  input  logic       tx_wr_i,
  input  logic [7:0] tx_wdata_i,
  input  logic       rxd_i,
  output logic [7:0] ctl_o,
  output logic [7:0] rx_data_o,
  output logic       txd_o,
  output logic       dat_o,
  output logic       dat_oe_o,
  output logic       tx_irq_o,
  output logic       rx_irq_o
);
  import sp_pkg::*;

  sp_ctl_t    ctl, wctl;
  sp_mode_e   mode;
  logic       async_md, os_tick;
  logic       tx_line, tx_fin;
  logic       rx_fin, rx_b9, rx_stop, rx_pass, acc_async;
  logic [7:0] rx_d;
  logic       m0_sclk, m0_tx_done, m0_rx_done, m0_rx_go, acc_m0;
  logic [7:0] m0_data;
  logic [7:0] rx_buf;

  assign wctl     = sp_ctl_t'(ctl_wdata_i);
  assign mode     = sp_mode_e'(ctl.mode);
  assign async_md = (mode != MD_SHIFT);

  sp_baud #(.FIX_DIV(FIX_DIV), .TMR_PRE(TMR_PRE), .OVS(OVS)) i_baud (
    .clk(clk), .rst(rst), .mode(ctl.mode), .dbl(dbl_i),
    .tmr_tick(tmr_tick_i), .os_tick(os_tick));

  sp_tx #(.OVS(OVS)) i_tx (
    .clk(clk), .rst(rst), .start(tx_wr_i && async_md), .nine(ctl.mode[1]),
    .os_tick(os_tick), .din(tx_wdata_i), .b9(ctl.tx_b9),
    .txd(tx_line), .done(tx_fin));

  sp_rx #(.OVS(OVS)) i_rx (
    .clk(clk), .rst(rst), .en(async_md && ctl.en_rx), .nine(ctl.mode[1]),
    .os_tick(os_tick), .rxd(rxd_i), .done(rx_fin), .dout(rx_d),
    .bit9(rx_b9), .stopb(rx_stop));

  assign m0_rx_go = ctl_wr_i && (sp_mode_e'(wctl.mode) == MD_SHIFT)
                    && wctl.en_rx && !wctl.rx_flag;

  sp_shift0 #(.DIV(SHIFT_DIV)) i_sh0 (
    .clk(clk), .rst(rst), .tx_go(tx_wr_i && !async_md), .rx_go(m0_rx_go),
    .din(tx_wdata_i), .rxd(rxd_i), .sclk(m0_sclk), .dout(dat_o),
    .doe(dat_oe_o), .tx_done(m0_tx_done), .rx_done(m0_rx_done),
    .rx_data(m0_data));

  // Frame acceptance: the filter rule depends on the frame length
  assign rx_pass   = (mode == MD_UART8) ? (!ctl.filt || rx_stop)
                                        : (!ctl.filt || rx_b9);
  assign acc_async = rx_fin && async_md && ctl.en_rx && !ctl.rx_flag && rx_pass;
  assign acc_m0    = m0_rx_done && ctl.en_rx && !ctl.rx_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= '0;
      rx_buf <= '0;
    end else begin
      if (ctl_wr_i) ctl <= wctl;
      if (tx_fin || m0_tx_done) ctl.tx_flag <= 1'b1;
      if (acc_async) begin
        ctl.rx_flag <= 1'b1;
        ctl.rx_b9   <= (mode == MD_UART8) ? rx_stop : rx_b9;
        rx_buf      <= rx_d;
      end else if (acc_m0) begin
        ctl.rx_flag <= 1'b1;
        rx_buf      <= m0_data;
      end
    end
  end

  assign ctl_o     = ctl;
  assign rx_data_o = rx_buf;
  assign tx_irq_o  = ctl.tx_flag;
  assign rx_irq_o  = ctl.rx_flag;
  assign txd_o     = async_md ? tx_line : m0_sclk;
endmodule

// File: rtl/sp_chk.sv
module sp_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr_i,
  input logic [7:0] ctl_o,
  input logic [7:0] rx_data_o,
  input logic       tx_irq_o,
  input logic       rx_irq_o
);
  AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    rx_irq_o && !ctl_wr_i |=> rx_irq_o); // R8
  AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    tx_irq_o && !ctl_wr_i |=> tx_irq_o); // R8
  AST_RXBUF_HELD: assert property (@(posedge clk) disable iff (rst)
    rx_irq_o |=> $stable(rx_data_o)); // R9
  AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq_o) && !$past(ctl_wr_i) && ctl_o[3] && ctl_o[1] |-> ctl_o[5]); // R7
  AST_RX_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq_o) && !$past(ctl_wr_i) |-> ctl_o[2]); // R10
endmodule

bind ser_port sp_chk i_sp_chk (
  .clk(clk), .rst(rst), .ctl_wr_i(ctl_wr_i), .ctl_o(ctl_o),
  .rx_data_o(rx_data_o), .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o));

// File: tb/test_ser_port.sv
module test_ser_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tmr_tick_i = 1'b0, dbl_i = 1'b0;
  logic       ctl_wr_i = 1'b0, tx_wr_i = 1'b0, rxd_i = 1'b1;
  logic [7:0] ctl_wdata_i = '0, tx_wdata_i = '0;
  logic [7:0] ctl_o, rx_data_o;
  logic       txd_o, dat_o, dat_oe_o, tx_irq_o, rx_irq_o;

  int checks = 0, failures = 0;
  logic [7:0] last_rx = 8'h00;

  always #2 clk = ~clk;

  ser_port i_ser_port (
    .clk(clk), .rst(rst), .tmr_tick_i(tmr_tick_i), .dbl_i(dbl_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .tx_wr_i(tx_wr_i),
    .tx_wdata_i(tx_wdata_i), .rxd_i(rxd_i), .ctl_o(ctl_o),
    .rx_data_o(rx_data_o), .txd_o(txd_o), .dat_o(dat_o),
    .dat_oe_o(dat_oe_o), .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o));

  // vector: [13:12] mode, [11] dbl, [10] filter, [9] ninth, [8:1] data, [0] accept
  localparam logic [13:0] VEC [8] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'h81, 1'b1},
    {2'd2, 1'b1, 1'b1, 1'b0, 8'h5A, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b1, 8'hC3, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b0, 8'h0F, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1}
  };

  initial begin : tick_gen
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc == 2) ? 0 : tc + 1;
      tmr_tick_i = (tc == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bper(input logic [1:0] m, input logic d);
    case (m)
      2'd0: return 12;
      2'd2: return d ? 32 : 64;
      default: return d ? 48 : 96;
    endcase
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr_i = 1'b1; ctl_wdata_i = v;
    @(negedge clk); ctl_wr_i = 1'b0;
  endtask

  task automatic wr_tx(input logic [7:0] v);
    @(negedge clk); tx_wr_i = 1'b1; tx_wdata_i = v;
    @(negedge clk); tx_wr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic capture_tx(input int per, input int n, output logic [10:0] got);
    int w = 0;
    got = '1;
    while (txd_o !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
    idle(per / 2);
    got[0] = txd_o;
    for (int i = 1; i < n; i++) begin
      idle(per);
      got[i] = txd_o;
    end
  endtask

  task automatic drive_rx(input logic [10:0] bits, input int n, input int per);
    for (int i = 0; i < n; i++) begin
      rxd_i = bits[i];
      idle(per);
    end
    rxd_i = 1'b1;
    idle(2 * per);
  endtask

  task automatic wait_flag(input bit want_rx, input int maxc);
    int w = 0;
    while (((want_rx ? rx_irq_o : tx_irq_o) !== 1'b1) && w < maxc) begin
      @(negedge clk); w++;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [10:0] got;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(ctl_o == 8'h00, "R1 reset ctl", ctl_o, 0);
    chk(txd_o == 1'b1, "R1 reset txd", txd_o, 1);
    chk(!tx_irq_o && !rx_irq_o && !dat_oe_o, "R1 reset flags", {tx_irq_o, rx_irq_o, dat_oe_o}, 0);
    wr_ctl(8'h1D);
    chk(ctl_o == 8'h1D, "R1 readback", ctl_o, 8'h1D);

    // table of asynchronous transmit and receive cases
    for (int v = 0; v < 8; v++) begin
      logic [1:0] m;  logic d, f, b9, acc;  logic [7:0] dat;
      int per, n;  logic [10:0] fr;
      m = VEC[v][13:12]; d = VEC[v][11]; f = VEC[v][10]; b9 = VEC[v][9];
      dat = VEC[v][8:1]; acc = VEC[v][0];
      per = bper(m, d);  n = m[1] ? 11 : 10;
      dbl_i = d;
      wr_ctl({3'b000, b9, f, 1'b1, m});
      wr_tx(dat);
      capture_tx(per, n, got);
      chk(got[0] == 1'b0, "R4 start bit", got[0], 0);
      chk(got[8:1] == dat, m[1] ? "R5 data bits" : "R4 data bits", got[8:1], dat);
      if (m[1]) begin
        chk(got[9] == b9, "R5 ninth bit", got[9], b9);
        chk(got[10] == 1'b1, "R5 stop bit", got[10], 1);
      end else begin
        chk(got[9] == 1'b1, "R4 stop bit", got[9], 1);
      end
      wait_flag(1'b0, 4 * per);
      chk(tx_irq_o == 1'b1, "R8 tx flag set", tx_irq_o, 1);
      wr_ctl({3'b000, b9, f, 1'b1, m});
      chk(tx_irq_o == 1'b0, "R8 tx flag cleared", tx_irq_o, 0);
      fr = m[1] ? {1'b1, b9, dat, 1'b0} : {1'b1, 1'b1, dat, 1'b0};
      drive_rx(fr, n, per);
      chk(rx_irq_o == acc, "R7 rx flag vs filter", rx_irq_o, acc);
      if (acc) begin
        last_rx = dat;
        chk(ctl_o[5] == (m[1] ? b9 : 1'b1), "R6 received ninth bit", ctl_o[5], m[1] ? b9 : 1'b1);
      end
      chk(rx_data_o == last_rx, "R6 rx data", rx_data_o, last_rx);
    end
    dbl_i = 1'b0;

    // R2: mode 0 transmit
    wr_ctl(8'h00);
    wr_tx(8'hB4);
    begin
      realtime t0, t1;
      for (int i = 0; i < 8; i++) begin
        @(posedge txd_o);
        if (i == 0) t0 = $realtime;
        if (i == 1) begin
          t1 = $realtime;
          chk((t1 - t0) == 48.0, "R2 shift clock period", int'(t1 - t0), 48);
        end
        @(negedge clk);
        chk(dat_o == 1'((8'hB4 >> i) & 8'h01) && dat_oe_o, "R2 shift data bit", dat_o, (8'hB4 >> i) & 1);
      end
    end
    wait_flag(1'b0, 60);
    chk(tx_irq_o == 1'b1, "R2 tx flag after shift", tx_irq_o, 1);

    // R3: mode 0 receive
    rxd_i = 1'b0;
    wr_ctl(8'h04);
    for (int i = 1; i < 8; i++) begin
      @(negedge txd_o);
      rxd_i = 1'((8'h6C >> i) & 8'h01);
    end
    wait_flag(1'b1, 60);
    rxd_i = 1'b1;
    chk(rx_irq_o == 1'b1, "R3 rx flag", rx_irq_o, 1);
    chk(rx_data_o == 8'h6C, "R3 rx data", rx_data_o, 8'h6C);

    // R9: flag still set blocks a new frame
    wr_ctl(8'h85);
    drive_rx({1'b1, 1'b1, 8'h11, 1'b0}, 10, 96);
    chk(rx_data_o == 8'h6C, "R9 buffer held", rx_data_o, 8'h6C);
    chk(rx_irq_o == 1'b1, "R9 flag held", rx_irq_o, 1);
    wr_ctl(8'h05);
    chk(rx_irq_o == 1'b0, "R8 rx flag cleared by write", rx_irq_o, 0);
    drive_rx({1'b1, 1'b1, 8'h11, 1'b0}, 10, 96);
    chk(rx_data_o == 8'h11 && rx_irq_o, "R9 receive after clear", rx_data_o, 8'h11);

    // R6: false start bit
    wr_ctl(8'h05);
    rxd_i = 1'b0; idle(12); rxd_i = 1'b1; idle(300);
    chk(rx_irq_o == 1'b0, "R6 false start rejected", rx_irq_o, 0);
    chk(rx_data_o == 8'h11, "R6 buffer after false start", rx_data_o, 8'h11);

    // R7: mode 1 bad stop with and without the filter
    wr_ctl(8'h0D);
    drive_rx({1'b1, 1'b0, 8'h77, 1'b0}, 10, 96);
    chk(rx_irq_o == 1'b0, "R7 bad stop dropped", rx_irq_o, 0);
    chk(rx_data_o == 8'h11, "R7 buffer unchanged", rx_data_o, 8'h11);
    wr_ctl(8'h05);
    drive_rx({1'b1, 1'b0, 8'h77, 1'b0}, 10, 96);
    chk(rx_irq_o == 1'b1 && rx_data_o == 8'h77, "R7 bad stop accepted", rx_data_o, 8'h77);
    chk(ctl_o[5] == 1'b0, "R7 stop bit in ninth field", ctl_o[5], 0);

    // R10: receiver disabled
    wr_ctl(8'h01);
    drive_rx({1'b1, 1'b1, 8'h99, 1'b0}, 10, 96);
    chk(rx_irq_o == 1'b0 && rx_data_o == 8'h77, "R10 async disabled", rx_data_o, 8'h77);
    wr_ctl(8'h00);
    begin
      bit low_seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (txd_o == 1'b0) low_seen = 1'b1;
      end
      chk(!low_seen && !rx_irq_o, "R10 mode 0 no clock", low_seen, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule